// File: doc/BRIEF.md
# Stream Command Completion Timer

This block checks one streaming read or write command against a completion deadline. A start strobe marks the write of the command register. At that point the block picks the deadline in microseconds and loads a down-counter with it. The counter then decrements once per 1 MHz tick enable until the command completes.

The deadline comes from one of two places:
- If the command's feature byte is nonzero, the deadline is that byte multiplied by a 16-bit unit value.
- If the byte is zero, the deadline comes from a default table. The table holds one entry per stream ID and per direction, and each entry is written by a configure strobe.

A deadline of zero means the command is never timed out.

Completion happens at the final interrupt strobe. When the command asked for a flush, completion waits until a flush-done strobe has also been seen. At completion the block records how the command ended:
- The stream-error status bit is set when write-continue was requested and the full transfer length moved.
- Otherwise, the error status bit is set when the deadline expired or the transfer came up short.

Top module: `stream_deadline_timer`

## Requirements
- R1: After reset, `busy`, `cmp`, `st_se`, `st_err` and every bit of `err_reg` are 0, and every default table entry is 0.
- R2: With a nonzero `cmd_feat`, the deadline is `cmd_feat * unit_us` ticks. `err_reg[0]` rises in the cycle after the tick that brings the count to zero, and not before.
- R3: With `cmd_feat` equal to 0, the deadline is the default entry addressed by `cmd_wr` (1 = write, 0 = read) and `cmd_id`. Read and write entries are separate. An entry is written by `cfg_we` with `cfg_wr`, `cfg_id` and `cfg_limit`.
- R4: A deadline of zero, whether from a zero default or a zero `unit_us`, never sets `err_reg[0]`, however many ticks arrive.
- R5: The timeout flag is bit 0 of `err_reg` and bits 7:1 are always 0. Once set, the flag holds until the next `cmd_start`, including after completion.
- R6: `cmd_start` at any time clears `err_reg`, `st_se` and `st_err`, reloads the counter and sets `busy` in the next cycle. A start while busy restarts the deadline from the full value.
- R7: Ticks count only between start and completion. Ticks while idle never set the flag.
- R8: At completion, if `cmd_wc` was set at start and `xfer_full` was 1 at the first `xfer_done`, then `st_se` is 1 and `st_err` is 0.
- R9: Otherwise, at completion `st_se` is 0 and `st_err` is 1 exactly when the deadline expired or `xfer_full` was 0.
- R10: When `cmd_flush` was set at start, completion waits for both `xfer_done` and `flush_done`. Completion shows as a one-cycle `cmp` pulse, with `busy` low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-microsecond tick enable |
| cfg_we | input | 1 | Default-limit write strobe |
| cfg_wr | input | 1 | Direction of default entry (1 = write) |
| cfg_id | input | 3 | Stream ID of default entry |
| cfg_limit | input | 24 | Default limit in microseconds |
| cmd_start | input | 1 | Command-register write strobe |
| cmd_wr | input | 1 | Command direction (1 = write) |
| cmd_id | input | 3 | Command stream ID |
| cmd_feat | input | 8 | Feature byte for the limit |
| unit_us | input | 16 | Time unit multiplier in microseconds |
| cmd_flush | input | 1 | Flush required before completion |
| cmd_wc | input | 1 | Write-continue requested |
| xfer_done | input | 1 | Final interrupt strobe |
| xfer_full | input | 1 | Full transfer length moved, valid with xfer_done |
| flush_done | input | 1 | Media commit finished |
| busy | output | 1 | Command in progress |
| cmp | output | 1 | One-cycle completion pulse |
| err_reg | output | 8 | Error byte, bit 0 is completion timeout |
| st_se | output | 1 | Stream-error status bit |
| st_err | output | 1 | Error status bit |

## Verification
The bench goes after the exact tick where the deadline expires. A counter off by one would flag one tick early or one tick late on limits such as 1 and 3. It feeds zero feature bytes against table entries that differ for read and write, so a design that mixes up the two directions or the IDs flags at the wrong time. It also sends zero limits, ticks after completion and restarts in mid-count; a design that wrapped its counter or did not reload it would report spurious timeouts. Finally, it holds a flush command after the interrupt and checks the write-continue outcome against a late or short transfer, where a wrong priority would set both status bits or complete early.

// File: rtl/stream_deadline_timer.sv
module stream_deadline_timer #(
  parameter int IDS    = 8,
  parameter int FEAT_W = 8,
  parameter int UNIT_W = 16,
  localparam int CNT_W = FEAT_W + UNIT_W,
  localparam int ID_W  = $clog2(IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              cfg_we,
  input  logic              cfg_wr,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              cmd_start,
  input  logic              cmd_wr,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [FEAT_W-1:0] cmd_feat,
  input  logic [UNIT_W-1:0] unit_us,
  input  logic              cmd_flush,
  input  logic              cmd_wc,
  input  logic              xfer_done,
  input  logic              xfer_full,
  input  logic              flush_done,
  output logic              busy,
  output logic              cmp,
  output logic [7:0]        err_reg,
  output logic              st_se,
  output logic              st_err
);

  logic [CNT_W-1:0] dflt [2][IDS];
  logic [CNT_W-1:0] cnt, lim_new;
  logic armed, tmo, done_seen, full_q, flush_q, flushed, wc_q;
  logic fin, full_now;

  assign lim_new  = (cmd_feat != '0) ? CNT_W'(cmd_feat) * CNT_W'(unit_us)
                                     : dflt[cmd_wr][cmd_id];
  assign full_now = done_seen ? full_q : xfer_full;
  assign fin      = busy && (xfer_done || done_seen) &&
                    (!flush_q || flushed || flush_done);
  assign err_reg  = {7'b0, tmo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < IDS; i++)
          dflt[d][i] <= '0;
    end else if (cfg_we) begin
      dflt[cfg_wr][cfg_id] <= cfg_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cmp       <= 1'b0;
      cnt       <= '0;
      armed     <= 1'b0;
      tmo       <= 1'b0;
      done_seen <= 1'b0;
      full_q    <= 1'b0;
      flush_q   <= 1'b0;
      flushed   <= 1'b0;
      wc_q      <= 1'b0;
      st_se     <= 1'b0;
      st_err    <= 1'b0;
    end else if (cmd_start) begin
      busy      <= 1'b1;
      cmp       <= 1'b0;
      cnt       <= lim_new;
      armed     <= (lim_new != '0);
      tmo       <= 1'b0;
      done_seen <= 1'b0;
      full_q    <= 1'b0;
      flush_q   <= cmd_flush;
      flushed   <= 1'b0;
      wc_q      <= cmd_wc;
      st_se     <= 1'b0;
      st_err    <= 1'b0;
    end else begin
      cmp <= 1'b0;
      if (busy) begin
        if (xfer_done && !done_seen) begin
          done_seen <= 1'b1;
          full_q    <= xfer_full;
        end
        if (flush_done) flushed <= 1'b1;
        if (fin) begin
          busy   <= 1'b0;
          cmp    <= 1'b1;
          st_se  <= wc_q && full_now;
          st_err <= !(wc_q && full_now) && (tmo || !full_now);
        end else if (tick_us && armed && !tmo) begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) tmo <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stream_deadline_timer_chk.sv
module stream_deadline_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_us,
  input logic       cmd_start,
  input logic       busy,
  input logic       cmp,
  input logic [7:0] err_reg,
  input logic       st_se,
  input logic       st_err
);

  assert_start_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> busy && err_reg == 8'h00 && !st_se && !st_err);

  assert_cmp_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |-> !busy && $past(busy));

  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_se && st_err));

  assert_tmo_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_reg[0]) |-> $past(tick_us) && $past(busy));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_reg[0] && !cmd_start |=> err_reg[0]);

  assert_idle_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_start |=> $stable(st_se) && $stable(st_err));

endmodule

bind stream_deadline_timer stream_deadline_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cmd_start(cmd_start),
  .busy(busy), .cmp(cmp), .err_reg(err_reg), .st_se(st_se), .st_err(st_err)
);

// File: tb/sim_stream_deadline_timer.sv
module sim_stream_deadline_timer;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_us = 0, cfg_we = 0, cfg_wr = 0, cmd_start = 0, cmd_wr = 0;
  logic [2:0] cfg_id = 0, cmd_id = 0;
  logic [23:0] cfg_limit = 0;
  logic [7:0] cmd_feat = 0;
  logic [15:0] unit_us = 0;
  logic cmd_flush = 0, cmd_wc = 0, xfer_done = 0, xfer_full = 0, flush_done = 0;
  logic busy, cmp, st_se, st_err;
  logic [7:0] err_reg;

  int n_run = 0, n_fail = 0, cyc = 0;
  int mdl [2][8];

  always #(CLK_P/2) clk = ~clk;

  stream_deadline_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_we(cfg_we), .cfg_wr(cfg_wr),
    .cfg_id(cfg_id), .cfg_limit(cfg_limit), .cmd_start(cmd_start), .cmd_wr(cmd_wr),
    .cmd_id(cmd_id), .cmd_feat(cmd_feat), .unit_us(unit_us), .cmd_flush(cmd_flush),
    .cmd_wc(cmd_wc), .xfer_done(xfer_done), .xfer_full(xfer_full),
    .flush_done(flush_done), .busy(busy), .cmp(cmp), .err_reg(err_reg),
    .st_se(st_se), .st_err(st_err));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input bit wr, input int id, input int feat, input int unit);
    return (feat != 0) ? feat * unit : mdl[wr][id];
  endfunction

  task automatic cfg(input bit wr, input int id, input int lim);
    @(negedge clk);
    cfg_we = 1; cfg_wr = wr; cfg_id = 3'(id); cfg_limit = 24'(lim);
    @(negedge clk);
    cfg_we = 0;
    mdl[wr][id] = lim;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1; @(negedge clk);
      tick_us = 0; @(negedge clk);
    end
  endtask

  task automatic start(input bit wr, input int id, input int feat, input int unit,
                       input bit wc, input bit fl);
    @(negedge clk);
    cmd_wr = wr; cmd_id = 3'(id); cmd_feat = 8'(feat); unit_us = 16'(unit);
    cmd_wc = wc; cmd_flush = fl; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic run_cmd(input bit wr, input int id, input int feat, input int unit,
                         input bit wc, input bit full, input bit fl, input int nt,
                         input string req);
    int lim;
    bit et, ese, eer;
    lim = lim_of(wr, id, feat, unit);
    et  = (lim != 0) && (nt >= lim);
    ese = wc && full;
    eer = !ese && (et || !full);
    start(wr, id, feat, unit, wc, fl);
    chk(busy == 1'b1 && err_reg == 0, "R6 start", int'(busy), 1);
    ticks(nt);
    xfer_done = 1; xfer_full = full;
    @(negedge clk);
    xfer_done = 0;
    if (fl) begin
      chk(cmp == 1'b0 && busy == 1'b1, "R10 flush hold", int'(cmp), 0);
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R10 flush wait", int'(busy), 1);
      flush_done = 1;
      @(negedge clk);
      flush_done = 0;
    end
    chk(cmp == 1'b1 && busy == 1'b0, {req, " R10 cmp"}, int'(cmp), 1);
    chk(err_reg == {7'b0, et}, {req, " R2 timeout flag"}, int'(err_reg), int'(et));
    chk(st_se == ese, {req, " R8 se"}, int'(st_se), int'(ese));
    chk(st_err == eer, {req, " R9 err"}, int'(st_err), int'(eer));
    @(negedge clk);
    chk(cmp == 1'b0, "R10 single pulse", int'(cmp), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int d = 0; d < 2; d++) for (int i = 0; i < 8; i++) mdl[d][i] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && cmp == 0 && err_reg == 0 && st_se == 0 && st_err == 0,
        "R1 reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: defaults start at zero, so no timeout from the table
    run_cmd(1, 5, 0, 0, 0, 1, 0, 20, "R1 zero default");
    // R2: exact boundary, limit 3
    run_cmd(0, 0, 3, 1, 0, 1, 0, 2, "R2 below");
    run_cmd(0, 0, 3, 1, 0, 1, 0, 3, "R2 at");
    run_cmd(0, 0, 1, 1, 0, 1, 0, 1, "R2 limit one");
    // R3: per-direction defaults
    cfg(1, 3, 4);
    cfg(0, 3, 9);
    run_cmd(0, 3, 0, 7, 0, 1, 0, 5, "R3 read default");
    run_cmd(1, 3, 0, 7, 0, 1, 0, 5, "R3 write default");
    // R4: zero unit with nonzero feature byte
    run_cmd(0, 1, 5, 0, 0, 1, 0, 30, "R4 zero unit");
    // R8 / R9 outcomes with timeout and short transfer
    run_cmd(1, 2, 2, 1, 1, 1, 0, 5, "R8 wc full late");
    run_cmd(1, 2, 2, 1, 1, 0, 0, 0, "R9 wc short");
    run_cmd(0, 2, 2, 2, 0, 0, 0, 0, "R9 short");
    // R10 flush with timeout during flush wait
    start(1, 4, 2, 1, 0, 1);
    ticks(1);
    xfer_done = 1; xfer_full = 1; @(negedge clk); xfer_done = 0;
    ticks(1);
    chk(err_reg == 8'h01 && busy == 1, "R10 timer runs during flush", int'(err_reg), 1);
    flush_done = 1; @(negedge clk); flush_done = 0;
    chk(cmp == 1 && st_err == 1, "R10 flush completion", int'(st_err), 1);
    // R5: flag held after completion; R7: idle ticks ignored
    ticks(4);
    chk(err_reg == 8'h01, "R5 flag held", int'(err_reg), 1);
    run_cmd(0, 0, 10, 1, 0, 1, 0, 2, "R7 early done");
    ticks(15);
    chk(err_reg == 8'h00 && busy == 0, "R7 idle ticks ignored", int'(err_reg), 0);
    // R6: restart in mid-count reloads
    start(0, 0, 3, 1, 0, 0);
    ticks(2);
    start(0, 0, 3, 1, 0, 0);
    ticks(2);
    chk(err_reg == 8'h00, "R6 reload", int'(err_reg), 0);
    ticks(1);
    chk(err_reg == 8'h01, "R6 reload expire", int'(err_reg), 1);
    xfer_done = 1; xfer_full = 1; @(negedge clk); xfer_done = 0;
    @(negedge clk);

    // random mix
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 8; i++)
        cfg(d[0], i, ($urandom % 4 == 0) ? 0 : int'($urandom_range(1, 20)));
    for (int k = 0; k < 150; k++) begin
      bit wr, wc, full, fl;
      int id, feat, unit, lim, nt;
      wr = 1'($urandom); id = int'($urandom_range(0, 7));
      feat = ($urandom % 3 == 0) ? 0 : int'($urandom_range(1, 8));
      unit = int'($urandom_range(0, 6));
      wc = 1'($urandom); full = ($urandom % 4) != 0; fl = ($urandom % 4) == 0;
      if ($urandom % 10 == 0)
        cfg(1'($urandom), int'($urandom_range(0, 7)), int'($urandom_range(0, 20)));
      lim = lim_of(wr, id, feat, unit);
      nt = int'($urandom_range(0, 2 + ((lim > 50) ? 50 : lim)));
      run_cmd(wr, id, feat, unit, wc, full, fl, nt, "rand R2 R3 R8 R9");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule